// File: doc/BRIEF.md
# Sixteen-Pin Output Port with Atomic Set and Clear

This block is a small register file that drives a 16-bit output pin vector and samples a 16-bit input pin vector, and it sits on a simple 32-bit memory-mapped bus. Software can rewrite the whole output word in one access. It can also change selected output bits without a read-modify-write sequence, by writing a mask word to a set/clear register or to a clear-only register. Each such write takes effect in a single clock cycle and leaves the other bits as they were.

The set/clear word carries two masks. The upper half-word holds the bits to clear and the lower half-word holds the bits to set. When both masks select the same bit, the set wins. The clear-only register behaves as if its value had been shifted into the upper half of the set/clear word. The input pins pass through a two-flop synchronizer before a bus read can see them.

The bus uses a one-cycle valid strobe with a write enable, a byte address and 32-bit write data. Read data is registered and is returned one cycle after the strobe.

Top module: `gpioSetClrPort`

## Requirements
- R1: A write to offset 0x0C replaces all 16 output bits with write-data bits [15:0] on the clock edge of the strobe; write-data bits [31:16] have no effect.
- R2: A write to offset 0x10 drives to 1 every output bit whose matching bit in write-data [15:0] is 1.
- R3: A write to offset 0x10 drives to 0 every output bit whose matching bit in write-data [31:16] is 1 and whose set bit is 0. Bits that are 0 in both masks keep their value, and the outputs hold steady on cycles with no output write.
- R4: When a write to offset 0x10 has a 1 at bit n and at bit n+16, output bit n becomes 1.
- R5: A write to offset 0x14 clears every output bit whose matching bit in write-data [15:0] is 1; write-data bits [31:16] are ignored.
- R6: A read strobe to offset 0x0C returns {16'h0, output bits} on busRdata in the cycle after the strobe; in any cycle that does not follow a read strobe, busRdata is zero.
- R7: A read of offset 0x08 returns {16'h0, pins} where the pins were sampled two clock edges before the read edge, through a two-flop synchronizer.
- R8: Reads of offsets 0x10, 0x14 and of any unmapped offset return zero; writes to offset 0x08 or to an unmapped offset change no output.
- R9: While reset is asserted (active low), the outputs and busRdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | One-cycle access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data, valid one cycle after a read strobe |
| pinIn | input | 16 | Input pin vector, asynchronous to clk |
| pinOut | output | 16 | Output pin vector |

## Verification
Output-bit writes show on pinOut right after the edge that samples the strobe, and read data shows on busRdata right after the edge that samples a read strobe. The bench therefore compares both outputs against its reference model at the falling edge after every rising edge. The input register lags the pins by two edges. The model keeps a queue of the pin values seen at each edge and answers an input read with the entry from two edges earlier, so back-to-back reads taken while the pins change are each checked in the right cycle.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_PIN_IN  = 8'h08;
  localparam logic [7:0] OFS_OUT     = 8'h0C;
  localparam logic [7:0] OFS_SET_CLR = 8'h10;
  localparam logic [7:0] OFS_CLR     = 8'h14;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_IN   = 2'd1,
    SEL_OUT  = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrSetClr;
    logic   wrClr;
    logic   rdEn;
    rdSel_e rdSel;
  } portStrb_t;

endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output portStrb_t         strb
);

  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFS_PIN_IN);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_SC  = ADDR_W'(OFS_SET_CLR);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

  logic isWr;
  logic isRd;

  assign isWr = busValid & busWrite;
  assign isRd = busValid & ~busWrite;

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_ZERO;
    strb.rdEn     = isRd;
    strb.wrOut    = isWr && (busAddr == A_OUT);
    strb.wrSetClr = isWr && (busAddr == A_SC);
    strb.wrClr    = isWr && (busAddr == A_CLR);
    if (isRd) begin
      if (busAddr == A_IN)       strb.rdSel = SEL_IN;
      else if (busAddr == A_OUT) strb.rdSel = SEL_OUT;
      else                       strb.rdSel = SEL_ZERO;
    end
  end

  // R8
  strb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOut, strb.wrSetClr, strb.wrClr, strb.rdEn}));

  // R8
  wr_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |-> !strb.rdEn);

endmodule

// File: rtl/gpioPortData.sv
module gpioPortData
  import gpioPortPkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrb_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - PIN_W;

  logic [PIN_W-1:0] setMask;
  logic [PIN_W-1:0] clrMask;
  logic [PIN_W-1:0] outNext;
  logic [PIN_W-1:0] outReg;
  logic [PIN_W-1:0] syncStage [SYNC_N];
  logic [PIN_W-1:0] pinSynced;
  logic [DATA_W-1:0] rdNext;

  assign setMask = wdata[PIN_W-1:0];
  assign clrMask = wdata[2*PIN_W-1:PIN_W];

  // Input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign pinSynced = syncStage[SYNC_N-1];

  // Per-bit next-state: set beats clear
  for (genvar b = 0; b < PIN_W; b++) begin : g_bit
    always_comb begin
      outNext[b] = outReg[b];
      if (strb.wrOut)
        outNext[b] = setMask[b];
      else if (strb.wrSetClr) begin
        if (setMask[b])      outNext[b] = 1'b1;
        else if (clrMask[b]) outNext[b] = 1'b0;
      end else if (strb.wrClr && setMask[b])
        outNext[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else       outReg <= outNext;
  end

  assign pinOut = outReg;

  always_comb begin
    rdNext = '0;
    if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_IN:  rdNext = {{PAD_W{1'b0}}, pinSynced};
        SEL_OUT: rdNext = {{PAD_W{1'b0}}, outReg};
        default: rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else       rdata <= rdNext;
  end

  // R1
  wr_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrOut |=> pinOut == $past(setMask));

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetClr |=> (pinOut & $past(setMask)) == $past(setMask));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetClr |=> (pinOut & $past(clrMask & ~setMask)) == '0);

  // R3
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetClr |=> ((pinOut ^ $past(pinOut)) & ~$past(setMask | clrMask)) == '0);

  // R5
  clr_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((pinOut & $past(setMask)) == '0) &&
                   ((pinOut ^ $past(pinOut)) & ~$past(setMask)) == '0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrOut || strb.wrSetClr || strb.wrClr) |=> $stable(pinOut));

  // R6
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> rdata == '0);

  // R6
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdata[DATA_W-1:PIN_W] == '0);

endmodule

// File: rtl/gpioSetClrPort.sv
module gpioSetClrPort
  import gpioPortPkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut
);

  portStrb_t strb;

  gpioPortCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  gpioPortData #(.PIN_W(PIN_W), .DATA_W(DATA_W), .SYNC_N(2)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .rdata  (busRdata)
  );

  // R9
  reset_out_chk: assert property (@(posedge clk)
    !rstN |-> (pinOut == '0) && (busRdata == '0));

endmodule

// File: tb/tb_gpioSetClrPort.sv
module tb_gpioSetClrPort;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 0;
  bit finished = 0;

  // reference model state
  logic [15:0] mOut = '0;
  logic [31:0] mRd = '0;
  logic [15:0] pinQ[$];
  logic [15:0] s2;
  string tag = "R9";

  gpioSetClrPort dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model, updated at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mOut = '0; mRd = '0; tag = "R9";
      pinQ.delete();
      pinQ.push_back('0); pinQ.push_back('0);
    end else begin
      s2 = pinQ.pop_front();
      pinQ.push_back(pinIn);
      mRd = '0;
      tag = "R3";
      if (busValid && !busWrite) begin
        case (busAddr)
          8'h08:   begin mRd = {16'h0, s2};   tag = "R7"; end
          8'h0C:   begin mRd = {16'h0, mOut}; tag = "R6"; end
          default: tag = "R8";
        endcase
      end else if (busValid && busWrite) begin
        case (busAddr)
          8'h0C: begin mOut = busWdata[15:0]; tag = "R1"; end
          8'h10: begin
            for (int i = 0; i < 16; i++) begin
              if (busWdata[i]) mOut[i] = 1'b1;
              else if (busWdata[i+16]) mOut[i] = 1'b0;
            end
            if ((busWdata[15:0] & busWdata[31:16]) != 0) tag = "R4";
            else if (busWdata[15:0] != 0) tag = "R2";
            else tag = "R3";
          end
          8'h14: begin mOut = mOut & ~busWdata[15:0]; tag = "R5"; end
          default: tag = "R8";
        endcase
      end
    end
    started = 1;
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (pinOut !== mOut) begin
        bad++;
        $display("FAIL %s pinOut actual=%h expected=%h t=%0t", tag, pinOut, mOut, $time);
      end
      checks++;
      if (busRdata !== mRd) begin
        bad++;
        $display("FAIL %s busRdata actual=%h expected=%h t=%0t", tag, busRdata, mRd, $time);
      end
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic busRd(input logic [7:0] a);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (pinOut !== 16'h0 || busRdata !== 32'h0) begin
      bad++;
      $display("FAIL R9 reset actual=%h/%h expected=0/0", pinOut, busRdata);
    end
    rstN = 1;
    @(negedge clk);
    busWr(8'h0C, 32'hFFFF_A5A5);   // R1 upper bits ignored
    busRd(8'h0C);                  // R6
    busWr(8'h10, 32'h0000_0F00);   // R2
    busWr(8'h10, 32'h00F0_0000);   // R3
    busWr(8'h10, 32'h0003_0003);   // R4
    busWr(8'h10, 32'h0000_0000);   // R3 no change
    busWr(8'h14, 32'h0000_A000);   // R5
    busWr(8'h14, 32'hFFFF_0000);   // R5 upper ignored
    busRd(8'h0C);
    busRd(8'h10);                  // R8
    busRd(8'h14);                  // R8
    busWr(8'h08, 32'hFFFF_FFFF);   // R8 ignored
    busWr(8'h20, 32'h0000_FFFF);   // R8 ignored
    busRd(8'h0C);
    busRd(8'h24);                  // R8
    // R7: pins change while reading back to back
    @(negedge clk); pinIn = 16'h1234;
    busValid = 1; busWrite = 0; busAddr = 8'h08;
    @(negedge clk); pinIn = 16'hBEEF;
    @(negedge clk); pinIn = 16'h0F0F;
    @(negedge clk);
    @(negedge clk); busValid = 0;
    // mixed pattern sweep
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      pinIn = r[31:16] ^ r[15:0];
      case (r[2:0])
        3'd0: busWr(8'h0C, $urandom);
        3'd1: busWr(8'h10, $urandom);
        3'd2: busWr(8'h14, $urandom);
        3'd3: busRd(8'h08);
        3'd4: busRd(8'h0C);
        3'd5: busWr(8'h10, {r[15:0], r[15:0]});
        3'd6: busRd({r[7:2], 2'b00});
        default: @(negedge clk);
      endcase
    end
    repeat (2) @(negedge clk);
    finish();
  end

endmodule